// File: doc/BRIEF.md
# Checked Pointer Add Unit

This unit decodes one 32-bit instruction word and, when it recognises the pointer-add opcode, forms a new address. It adds a base operand to an offset operand that has been shifted left by up to seven places. The base normally comes from a general register. A base index of 31 selects the stack pointer instead. The offset comes from a general register. An offset index of 31 reads as zero. The sum is written back either to a general register or, when the destination index is 31, to the stack pointer.

After the add, the unit compares the top byte of the sum with the top byte of the base. If an overflow or underflow has changed that byte, the result is corrupted in a fixed way, so that it is very unlikely to be usable as a valid address.

A small state register holds the write-back decision for one cycle. Its states are:
- WB_IDLE: no write-back.
- WB_GPR: write a general register.
- WB_SP: write the stack pointer.
- WB_UNDEF: raise the undefined-instruction flag.

The state is recomputed on every clock edge from the current inputs:
- Valid input low, or a word that does not decode: go to WB_IDLE.
- Decoded word with the feature disabled: go to WB_UNDEF.
- Decoded word with the feature enabled and destination index 31: go to WB_SP.
- Decoded word with the feature enabled and any other destination: go to WB_GPR.

Top module: `ptrchk_add_unit`

## Requirements
- R1: A word is accepted only when bits 31:21 equal 11'b10011010000 and bits 15:13 equal 3'b001. Any other word causes no write-back and no undefined flag.
- R2: The operand fields are fixed at these positions: offset register index at bits 20:16, shift amount at bits 12:10, base register index at bits 9:5 and destination index at bits 4:0.
- R3: The offset is the offset register value shifted left by the 3-bit shift amount (0 to 7). A shift amount of 0 leaves the value unshifted.
- R4: A base index of 31 uses the stack pointer input as the base.
- R5: A destination index of 31 writes the stack pointer (wb_sp_en_o) and does not write a general register.
- R6: The raw result is the base plus the shifted offset, modulo 2^64.
- R7: If bits 63:56 of the raw result equal bits 63:56 of the base, the raw result is written unchanged. If they differ, the written value is formed as follows: bits 63:56 come from the base with bit 62 inverted, and bits 55:0 come from the raw result.
- R8: A word that decodes while feat_en_i is low raises undef_o and performs no write-back.
- R9: An offset index of 31 gives an offset of zero.
- R10: All outputs are registered. The outputs for a stimulus presented before a rising edge appear after that edge and last one cycle. A cycle with valid_i low produces no write-back and no flag.
- R11: A synchronous reset clears both write enables, undef_o, the write index and the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | The instruction word is presented this cycle |
| insn_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | Enables the pointer-add operation |
| rf_ra_addr_o | output | 5 | General register read index for the base |
| rf_ra_data_i | input | 64 | Read data for the base index |
| rf_rb_addr_o | output | 5 | General register read index for the offset |
| rf_rb_data_i | input | 64 | Read data for the offset index |
| sp_i | input | 64 | Current stack pointer value |
| wb_gpr_en_o | output | 1 | Write enable for a general register |
| wb_sp_en_o | output | 1 | Write enable for the stack pointer |
| wb_idx_o | output | 5 | Destination general register index |
| wb_data_o | output | 64 | Write-back value |
| undef_o | output | 1 | Undefined-instruction flag |

## Verification
The read indices follow the instruction word in the same cycle. Every write-back output and the undefined flag are due exactly one rising edge after the word is presented.

The bench applies each stimulus at a falling edge and computes its expected outputs from its own register and stack-pointer model. It compares the outputs at the next falling edge, half a cycle after the capturing edge, so each comparison belongs to exactly one stimulus. Back-to-back operations, idle cycles and non-decoding words are mixed, which shows that a result never spills into a second cycle.

// File: rtl/ptrchk_pkg.sv
package ptrchk_pkg;
    localparam int unsigned INSN_W  = 32;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned SHAMT_W = 3;
    localparam logic [IDX_W-1:0] IDX_SPECIAL = '1;

    // Opcode bits that must match, split around the operand fields
    localparam logic [10:0] OPC_HI  = 11'b10011010000;
    localparam logic [2:0]  OPC_MID = 3'b001;

    typedef enum logic [1:0] {
        WB_IDLE  = 2'd0,
        WB_GPR   = 2'd1,
        WB_SP    = 2'd2,
        WB_UNDEF = 2'd3
    } wb_state_e;

    typedef struct packed {
        logic               hit;
        logic [IDX_W-1:0]   dst;
        logic [IDX_W-1:0]   src_base;
        logic [IDX_W-1:0]   src_off;
        logic [SHAMT_W-1:0] shamt;
    } dec_fields_t;
endpackage

// File: rtl/ptrchk_decode.sv
module ptrchk_decode
    import ptrchk_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_fields_t       fields
);
    always_comb begin
        fields.hit      = (insn[31:21] == OPC_HI) && (insn[15:13] == OPC_MID);
        fields.src_off  = insn[20:16];
        fields.shamt    = insn[12:10];
        fields.src_base = insn[9:5];
        fields.dst      = insn[4:0];
    end
endmodule

// File: rtl/ptrchk_operands.sv
module ptrchk_operands
    import ptrchk_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [IDX_W-1:0]   base_idx,
    input  logic [IDX_W-1:0]   off_idx,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [XLEN-1:0]    base_rf,
    input  logic [XLEN-1:0]    off_rf,
    input  logic [XLEN-1:0]    sp_val,
    output logic [XLEN-1:0]    base,
    output logic [XLEN-1:0]    offset
);
    logic [XLEN-1:0] stage [SHAMT_W+1];

    // Base select: index 31 means the stack pointer
    assign base     = (base_idx == IDX_SPECIAL) ? sp_val : base_rf;
    // Offset source: index 31 reads as zero
    assign stage[0] = (off_idx == IDX_SPECIAL) ? '0 : off_rf;

    // Log-depth left shifter, one stage per shift-amount bit
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_shift
        assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign offset = stage[SHAMT_W];
endmodule

// File: rtl/ptrchk_tagcheck.sv
module ptrchk_tagcheck #(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned TAG_W    = 8,
    parameter int unsigned FLIP_POS = 6
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] result,
    output logic            tag_bad
);
    localparam int unsigned LOW_W = XLEN - TAG_W;
    localparam logic [TAG_W-1:0] FLIP_MASK = TAG_W'(1) << FLIP_POS;

    logic [XLEN-1:0]  raw;
    logic [TAG_W-1:0] base_tag;

    assign raw      = base + offset;
    assign base_tag = base[XLEN-1 -: TAG_W];
    assign tag_bad  = raw[XLEN-1 -: TAG_W] != base_tag;
    assign result   = tag_bad ? {base_tag ^ FLIP_MASK, raw[LOW_W-1:0]} : raw;
endmodule

// File: rtl/ptrchk_add_unit.sv
module ptrchk_add_unit
    import ptrchk_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned TAG_W    = 8,
    parameter int unsigned FLIP_POS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [31:0]      insn_i,
    input  logic             feat_en_i,
    output logic [4:0]       rf_ra_addr_o,
    input  logic [XLEN-1:0]  rf_ra_data_i,
    output logic [4:0]       rf_rb_addr_o,
    input  logic [XLEN-1:0]  rf_rb_data_i,
    input  logic [XLEN-1:0]  sp_i,
    output logic             wb_gpr_en_o,
    output logic             wb_sp_en_o,
    output logic [4:0]       wb_idx_o,
    output logic [XLEN-1:0]  wb_data_o,
    output logic             undef_o
);
    dec_fields_t     dec;
    logic [XLEN-1:0] base_op, off_op, sum_chk;
    logic            tag_bad;
    wb_state_e       state_q, state_d;
    logic [4:0]      idx_q;
    logic [XLEN-1:0] data_q;

    ptrchk_decode u_dec (
        .insn   (insn_i),
        .fields (dec)
    );

    assign rf_ra_addr_o = dec.src_base;
    assign rf_rb_addr_o = dec.src_off;

    ptrchk_operands #(.XLEN(XLEN)) u_ops (
        .base_idx (dec.src_base),
        .off_idx  (dec.src_off),
        .shamt    (dec.shamt),
        .base_rf  (rf_ra_data_i),
        .off_rf   (rf_rb_data_i),
        .sp_val   (sp_i),
        .base     (base_op),
        .offset   (off_op)
    );

    ptrchk_tagcheck #(.XLEN(XLEN), .TAG_W(TAG_W), .FLIP_POS(FLIP_POS)) u_chk (
        .base    (base_op),
        .offset  (off_op),
        .result  (sum_chk),
        .tag_bad (tag_bad)
    );

    // Next-state selection
    always_comb begin
        if (!valid_i || !dec.hit)        state_d = WB_IDLE;
        else if (!feat_en_i)             state_d = WB_UNDEF;
        else if (dec.dst == IDX_SPECIAL) state_d = WB_SP;
        else                             state_d = WB_GPR;
    end

    // State and captured data
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WB_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= dec.dst;
            data_q  <= sum_chk;
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        wb_gpr_en_o = 1'b0;
        wb_sp_en_o  = 1'b0;
        undef_o     = 1'b0;
        unique case (state_q)
            WB_IDLE:  ;
            WB_GPR:   wb_gpr_en_o = 1'b1;
            WB_SP:    wb_sp_en_o  = 1'b1;
            WB_UNDEF: undef_o     = 1'b1;
            default:  ;
        endcase
    end

    assign wb_idx_o  = idx_q;
    assign wb_data_o = data_q;
endmodule

// File: rtl/ptrchk_add_unit_sva.sv
module ptrchk_add_unit_sva #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned TAG_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            valid_i,
    input logic [31:0]     insn_i,
    input logic            feat_en_i,
    input logic            dec_hit,
    input logic [XLEN-1:0] base_op,
    input logic            wb_gpr_en_o,
    input logic            wb_sp_en_o,
    input logic [XLEN-1:0] wb_data_o,
    input logic            undef_o
);
    // R10: at most one of the three results per cycle
    a_r10_one_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_gpr_en_o, wb_sp_en_o, undef_o}));

    // R1: a word that does not decode yields nothing next cycle
    a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !dec_hit) |=> !(wb_gpr_en_o || wb_sp_en_o || undef_o));

    // R8: feature disabled on a decoded word flags undefined
    a_r8_undef_flag: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec_hit && !feat_en_i) |=> (undef_o && !wb_gpr_en_o && !wb_sp_en_o));

    // R5: stack pointer write only for destination 31
    a_r5_sp_dest: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec_hit && feat_en_i) |=> (wb_sp_en_o == ($past(insn_i[4:0]) == 5'd31)));

    // R7: written top byte equals the base top byte, or that byte with bit 62 inverted
    a_r7_tag_rule: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec_hit && feat_en_i) |=>
            (((wb_data_o[XLEN-1 -: TAG_W] ^ $past(base_op[XLEN-1 -: TAG_W])) == '0) ||
             ((wb_data_o[XLEN-1 -: TAG_W] ^ $past(base_op[XLEN-1 -: TAG_W])) == TAG_W'(8'h40))));
endmodule

bind ptrchk_add_unit ptrchk_add_unit_sva #(.XLEN(XLEN), .TAG_W(TAG_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .insn_i      (insn_i),
    .feat_en_i   (feat_en_i),
    .dec_hit     (dec.hit),
    .base_op     (base_op),
    .wb_gpr_en_o (wb_gpr_en_o),
    .wb_sp_en_o  (wb_sp_en_o),
    .wb_data_o   (wb_data_o),
    .undef_o     (undef_o)
);

// File: tb/test_ptrchk_add_unit.sv
`timescale 1ns/1ps
module test_ptrchk_add_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] insn_i;
    logic        feat_en_i;
    logic [4:0]  ra_addr, rb_addr;
    logic [63:0] ra_data, rb_data, sp_i;
    logic        wb_gpr_en, wb_sp_en, undef;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;

    logic [63:0] gpr_m [32];
    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    assign ra_data = gpr_m[ra_addr];
    assign rb_data = gpr_m[rb_addr];

    ptrchk_add_unit i_ptrchk_add_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .feat_en_i(feat_en_i),
        .rf_ra_addr_o(ra_addr), .rf_ra_data_i(ra_data),
        .rf_rb_addr_o(rb_addr), .rf_rb_data_i(rb_data),
        .sp_i(sp_i), .wb_gpr_en_o(wb_gpr_en), .wb_sp_en_o(wb_sp_en),
        .wb_idx_o(wb_idx), .wb_data_o(wb_data), .undef_o(undef)
    );

    function automatic logic [31:0] enc(input int rd, input int rn, input int rm, input int sh);
        return {11'b10011010000, 5'(rm), 3'b001, 3'(sh), 5'(rn), 5'(rd)};
    endfunction

    // Behavioural reference for the write-back value
    function automatic logic [63:0] ref_val(input logic [31:0] w);
        logic [63:0] b, o, s;
        int rn, rm, sh;
        rn = int'(w[9:5]);
        rm = int'(w[20:16]);
        sh = int'(w[12:10]);
        b  = (rn == 31) ? sp_i : gpr_m[rn];
        o  = (rm == 31) ? 64'd0 : gpr_m[rm];
        for (int i = 0; i < sh; i++) o = o * 2;
        s = b + o;
        if (s[63:56] != b[63:56]) begin
            s[63:56] = b[63:56];
            s[62]    = ~s[62];
        end
        return s;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Apply at a falling edge; results are due after the next rising edge
    task automatic apply(input string tag, input logic v, input logic [31:0] w, input logic fe);
        logic is_op, e_gpr, e_sp, e_und;
        logic [63:0] e_data;
        valid_i   = v;
        insn_i    = w;
        feat_en_i = fe;
        #1;
        is_op  = v && (w[31:21] == 11'b10011010000) && (w[15:13] == 3'b001);
        e_und  = is_op && !fe;
        e_sp   = is_op && fe && (w[4:0] == 5'd31);
        e_gpr  = is_op && fe && (w[4:0] != 5'd31);
        e_data = ref_val(w);
        @(negedge clk);
        chk(tag, "gpr_en", 64'(wb_gpr_en), 64'(e_gpr));
        chk(tag, "sp_en",  64'(wb_sp_en),  64'(e_sp));
        chk(tag, "undef",  64'(undef),     64'(e_und));
        if (e_gpr) chk(tag, "idx", 64'(wb_idx), 64'(w[4:0]));
        if (e_gpr || e_sp) chk(tag, "data", wb_data, e_data);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) gpr_m[i] = 64'h0100_0000_0000_0000 * i + 64'h10 * i;
        gpr_m[3]  = 64'h0012_3456_789A_BCDE;
        gpr_m[4]  = 64'h0000_0000_0000_0100;
        gpr_m[5]  = 64'h00FF_FFFF_FFFF_FFF0;
        gpr_m[6]  = 64'h0000_0000_0000_0020;
        gpr_m[7]  = 64'hFFFF_FFFF_FFFF_FFF0;
        gpr_m[8]  = 64'h1200_0000_0000_1000;
        gpr_m[9]  = 64'hFFFF_FFFF_FFFF_FF00;
        gpr_m[31] = 64'hDEAD_BEEF_DEAD_BEEF;
        sp_i      = 64'h7F00_0000_0000_8000;
        rst = 1'b1; valid_i = 1'b0; insn_i = '0; feat_en_i = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "gpr_en", 64'(wb_gpr_en), 0);
        chk("R11", "sp_en",  64'(wb_sp_en), 0);
        chk("R11", "undef",  64'(undef), 0);
        chk("R11", "data",   wb_data, 0);
        chk("R11", "idx",    64'(wb_idx), 0);
        rst = 1'b0;

        apply("R2_R6 plain add",  1, enc(1, 3, 4, 0), 1);
        apply("R3 shift 7",        1, enc(2, 3, 4, 7), 1);
        apply("R3 shift 3",        1, enc(10, 8, 6, 3), 1);
        apply("R4 base sp",        1, enc(11, 31, 4, 2), 1);
        apply("R5 dest sp",        1, enc(31, 3, 4, 1), 1);
        apply("R9 offset zero",    1, enc(12, 3, 31, 5), 1);
        apply("R7 carry corrupt",  1, enc(13, 5, 6, 0), 1);
        apply("R6_R7 wrap",        1, enc(14, 7, 6, 0), 1);
        apply("R6 negative off",   1, enc(15, 8, 9, 0), 1);
        apply("R7 shift overflow", 1, enc(16, 3, 9, 7), 1);
        apply("R8 feature off",    1, enc(17, 3, 4, 0), 0);
        apply("R8 feature off sp", 1, enc(31, 31, 4, 0), 0);
        apply("R10 valid low",     0, enc(18, 3, 4, 0), 1);
        apply("R1 bad bits15_13",  1, enc(19, 3, 4, 0) ^ 32'h0000_6000, 1);
        apply("R1 bad bit31",      1, enc(19, 3, 4, 0) ^ 32'h8000_0000, 1);
        apply("R1 bad bit29",      1, enc(19, 3, 4, 0) ^ 32'h2000_0000, 1);
        apply("R1 bad bit21",      1, enc(19, 3, 4, 0) ^ 32'h0020_0000, 1);
        apply("R1 bad off feat",   1, enc(19, 3, 4, 0) ^ 32'h0100_0000, 0);
        apply("R5 sp both",        1, enc(31, 31, 31, 0), 1);
        apply("R10 back to back",  1, enc(20, 21, 22, 4), 1);
        apply("R10 idle after",    0, 32'h0, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule